// File: doc/BRIEF.md
# Command Fence and Interrupt Unit

This block sits next to a command-queue consumer and reports its progress to a host. The consumer signals three things: a fence event that carries a 32-bit value, a one-cycle pulse each time it makes forward progress, and a one-cycle pulse when the queue has been fully drained. The unit records the most recent fence value and compares each fence with a programmable goal. It collects three interrupt causes in a sticky status register and drives a single level-sensitive interrupt line through a mask.

The host reaches the unit over a simple register bus with an address, a write strobe, a read strobe and 32-bit data. A write to the sync register does three things: it raises a busy flag, it stores the written word as a reason code, and it sends a one-cycle wakeup pulse to the consumer without waiting for anything. The busy flag is a two-state machine, `ST_IDLE` and `ST_BUSY`. The sync write is the `ST_IDLE`→`ST_BUSY` transition. A drain pulse with no sync write in the same cycle is the `ST_BUSY`→`ST_IDLE` transition. Any other combination holds the current state.

Register addresses: 0 last fence (read), 1 fence goal (read/write), 2 interrupt mask (read/write, low 3 bits), 3 interrupt status (read, write-1-to-clear), 4 sync (write sets busy, read returns the reason code), 5 busy (read, bit 0). Status and mask bit positions: bit 0 is any fence, bit 1 is forward progress, bit 2 is fence goal reached. Read data is registered: it appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.

Top module: `fence_irq_unit`

## Requirements
- R1: After reset, last fence (addr 0) reads 0, goal (addr 1) reads 0xFFFFFFFF, mask (addr 2) reads 0, status (addr 3) reads 0, busy (addr 5) reads 0 and `irq` is low.
- R2: A fence event (`fence_valid` high for one cycle) copies `fence_value` into the last-fence register at address 0.
- R3: Every fence event sets status bit 0, whatever its value and whatever the mask.
- R4: A fence event sets status bit 2 only if its value equals the goal register and mask bit 2 is 1 in that cycle.
- R5: A `progress_pulse` sets status bit 1, whatever the mask.
- R6: Writing to address 3 clears exactly those status bits written as 1. Bits written as 0 keep their value.
- R7: If an event for a status bit arrives in the same cycle as a write that clears that bit, the bit ends up set.
- R8: `irq` is high exactly while some status bit and the same mask bit are both 1. It follows the registers one cycle after the edge that changes them.
- R9: A write to address 4 makes busy (addr 5, bit 0) read 1 from the next cycle on.
- R10: Busy stays 1 until a `drained_pulse` arrives in a cycle with no sync write. A drain that coincides with a sync write leaves busy at 1, and a drain while idle has no effect.
- R11: The last word written to address 4 reads back from address 4.
- R12: Each sync write produces `wake_pulse` high for exactly one cycle, in the cycle after the write edge, whatever the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fence_valid | input | 1 | Fence event strobe |
| fence_value | input | 32 | Value carried by the fence event |
| progress_pulse | input | 1 | Consumer made forward progress |
| drained_pulse | input | 1 | Consumer queue fully drained |
| wake_pulse | output | 1 | One-cycle wakeup toward the consumer |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The goal comparison is swept over all eight mask values. Each mask value is paired with fence values one below, equal to and one above the goal. This separates the match from a threshold test, and it separates the mask gating of bit 2 from the ungated bits 0 and 1 and from the gating applied at `irq`. Progress pulses go through the same mask sweep. Clear writes are tried with selective bit patterns and with an event in the same cycle, which shows whether write-1-to-clear is selective and whether the event wins. The busy handshake is tried with a drain on its own, a drain while idle, and a drain that coincides with a sync write. These cases separate a flag that clears only on drain from one that clears on a timer or on the wrong edge.

// File: rtl/fence_irq_pkg.sv
package fence_irq_pkg;

    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned SRC_ANY  = 0;
    localparam int unsigned SRC_PROG = 1;
    localparam int unsigned SRC_GOAL = 2;

    localparam int unsigned ADR_LAST = 0;
    localparam int unsigned ADR_GOAL = 1;
    localparam int unsigned ADR_MASK = 2;
    localparam int unsigned ADR_STAT = 3;
    localparam int unsigned ADR_SYNC = 4;
    localparam int unsigned ADR_BUSY = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sync_state_t;

endpackage

// File: rtl/fence_tracker.sv
module fence_tracker #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fence_valid,
    input  logic [DATA_W-1:0] fence_value,
    input  logic              goal_we,
    input  logic [DATA_W-1:0] goal_wdata,
    output logic [DATA_W-1:0] last_fence,
    output logic [DATA_W-1:0] goal,
    output logic              any_evt,
    output logic              goal_evt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_fence <= '0;
            goal       <= '1;
        end else begin
            if (fence_valid) last_fence <= fence_value;
            if (goal_we)     goal       <= goal_wdata;
        end
    end

    // Compare against the goal held before any same-cycle write
    always_comb begin
        any_evt  = fence_valid;
        goal_evt = fence_valid && (fence_value == goal);
    end

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int unsigned      NUM_SRC   = 3,
    parameter logic [NUM_SRC-1:0] GATE_SET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_bits,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    output logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask,
    output logic               irq
);

    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (GATE_SET[i]) begin : g_gated
            assign set_v[i] = evt[i] & mask[i];
        end else begin : g_open
            assign set_v[i] = evt[i];
        end
        assign clr_v[i] = clr_we & clr_bits[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import fence_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_we,
    input  logic [DATA_W-1:0] sync_wdata,
    input  logic              drained,
    output logic              busy,
    output logic              wake,
    output logic [DATA_W-1:0] reason
);

    sync_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wake    <= 1'b0;
            reason  <= '0;
        end else begin
            state_q <= state_d;
            wake    <= sync_we;
            if (sync_we) reason <= sync_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_we) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                busy = 1'b1;
                if (drained && !sync_we) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/fence_irq_unit.sv
module fence_irq_unit
    import fence_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fence_valid,
    input  logic [DATA_W-1:0] fence_value,
    input  logic              progress_pulse,
    input  logic              drained_pulse,
    output logic              wake_pulse,
    output logic              irq
);

    localparam logic [NUM_SRC-1:0] GATE = NUM_SRC'(1) << SRC_GOAL;

    logic              goal_we, mask_we, stat_we, sync_we;
    logic [DATA_W-1:0] last_w, goal_w, reason_w;
    logic              any_evt, goal_evt, busy_w;
    logic [NUM_SRC-1:0] evt_w, stat_w, mask_w;
    logic [DATA_W-1:0] rd_mux;

    assign goal_we = bus_wr && (bus_addr == ADDR_W'(ADR_GOAL));
    assign mask_we = bus_wr && (bus_addr == ADDR_W'(ADR_MASK));
    assign stat_we = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
    assign sync_we = bus_wr && (bus_addr == ADDR_W'(ADR_SYNC));

    fence_tracker #(.DATA_W(DATA_W)) u_fence (
        .clk        (clk),
        .rst_n      (rst_n),
        .fence_valid(fence_valid),
        .fence_value(fence_value),
        .goal_we    (goal_we),
        .goal_wdata (bus_wdata),
        .last_fence (last_w),
        .goal       (goal_w),
        .any_evt    (any_evt),
        .goal_evt   (goal_evt)
    );

    always_comb begin
        evt_w           = '0;
        evt_w[SRC_ANY]  = any_evt;
        evt_w[SRC_PROG] = progress_pulse;
        evt_w[SRC_GOAL] = goal_evt;
    end

    irq_status #(.NUM_SRC(NUM_SRC), .GATE_SET(GATE)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_w),
        .clr_we    (stat_we),
        .clr_bits  (bus_wdata[NUM_SRC-1:0]),
        .mask_we   (mask_we),
        .mask_wdata(bus_wdata[NUM_SRC-1:0]),
        .status    (stat_w),
        .mask      (mask_w),
        .irq       (irq)
    );

    sync_fsm #(.DATA_W(DATA_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_we   (sync_we),
        .sync_wdata(bus_wdata),
        .drained   (drained_pulse),
        .busy      (busy_w),
        .wake      (wake_pulse),
        .reason    (reason_w)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADR_LAST))      rd_mux = last_w;
        else if (bus_addr == ADDR_W'(ADR_GOAL)) rd_mux = goal_w;
        else if (bus_addr == ADDR_W'(ADR_MASK)) rd_mux = DATA_W'(mask_w);
        else if (bus_addr == ADDR_W'(ADR_STAT)) rd_mux = DATA_W'(stat_w);
        else if (bus_addr == ADDR_W'(ADR_SYNC)) rd_mux = reason_w;
        else if (bus_addr == ADDR_W'(ADR_BUSY)) rd_mux = DATA_W'(busy_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/fence_irq_chk.sv
module fence_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fence_valid,
    input logic       progress_pulse,
    input logic       drained_pulse,
    input logic       sync_we,
    input logic       mask_we,
    input logic       busy,
    input logic       wake,
    input logic       irq,
    input logic [2:0] status
);

    // R3 and R7: a fence always leaves the any-fence bit set
    a_r3_fence_sets_any: assert property (@(posedge clk) disable iff (!rst_n)
        fence_valid |=> status[0]);

    // R5 and R7: progress always leaves bit 1 set
    a_r5_progress_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        progress_pulse |=> status[1]);

    // R9: a sync write always leads to busy
    a_r9_sync_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sync_we |=> busy);

    // R10: busy only drops after a drain
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drained_pulse) |=> busy);

    // R12: each wake pulse follows a sync write
    a_r12_wake_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sync_we));

    // R8: the interrupt rises only after an event or a mask change
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fence_valid || progress_pulse || mask_we));

endmodule

bind fence_irq_unit fence_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fence_valid   (fence_valid),
    .progress_pulse(progress_pulse),
    .drained_pulse (drained_pulse),
    .sync_we       (sync_we),
    .mask_we       (mask_we),
    .busy          (busy_w),
    .wake          (wake_pulse),
    .irq           (irq),
    .status        (stat_w)
);

// File: tb/fence_irq_unit_test.sv
module fence_irq_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fence_valid = 1'b0;
    logic [31:0] fence_value = '0;
    logic        progress_pulse = 1'b0;
    logic        drained_pulse = 1'b0;
    logic        wake_pulse;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fence_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fence_valid(fence_valid), .fence_value(fence_value),
        .progress_pulse(progress_pulse), .drained_pulse(drained_pulse),
        .wake_pulse(wake_pulse), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_fence(input logic [31:0] v);
        @(negedge clk);
        fence_valid = 1'b1; fence_value = v;
        @(negedge clk);
        fence_valid = 1'b0;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        check(d == exp, tag, d, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] goal;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        expect_reg(4'd0, 32'h0, "R1 last fence");
        expect_reg(4'd1, 32'hFFFF_FFFF, "R1 goal");
        expect_reg(4'd2, 32'h0, "R1 mask");
        expect_reg(4'd3, 32'h0, "R1 status");
        expect_reg(4'd5, 32'h0, "R1 busy");

        // R2 R3 R4 R8: goal-match sweep over all masks
        goal = 32'h0000_1000;
        bus_write(4'd1, goal);
        expect_reg(4'd1, goal, "R4 goal readback");
        for (int m = 0; m < 8; m++) begin
            bus_write(4'd2, 32'(m));
            for (int k = -1; k <= 1; k++) begin
                logic [31:0] v;
                logic [2:0] exp_s;
                v = goal + 32'(k);
                bus_write(4'd3, 32'h7);
                send_fence(v);
                exp_s = 3'b001 | (((v == goal) && m[2]) ? 3'b100 : 3'b000);
                check(irq == |(exp_s & 3'(m)), "R8 irq after fence", 32'(irq), 32'(|(exp_s & 3'(m))));
                expect_reg(4'd3, 32'(exp_s), "R3/R4 status after fence");
                expect_reg(4'd0, v, "R2 last fence");
            end
            // R5 progress under this mask
            bus_write(4'd3, 32'h7);
            @(negedge clk); progress_pulse = 1'b1;
            @(negedge clk); progress_pulse = 1'b0;
            check(irq == m[1], "R5/R8 irq after progress", 32'(irq), 32'(m[1]));
            expect_reg(4'd3, 32'h2, "R5 status after progress");
        end

        // R8: mask change alone raises and lowers irq
        bus_write(4'd2, 32'h0);
        bus_write(4'd3, 32'h7);
        send_fence(32'h5);
        check(irq == 1'b0, "R8 masked", 32'(irq), 0);
        bus_write(4'd2, 32'h1);
        check(irq == 1'b1, "R8 unmasked", 32'(irq), 1);

        // R6 selective clear
        @(negedge clk); progress_pulse = 1'b1;
        @(negedge clk); progress_pulse = 1'b0;
        bus_write(4'd3, 32'h0);
        expect_reg(4'd3, 32'h3, "R6 write zero keeps");
        bus_write(4'd3, 32'h2);
        expect_reg(4'd3, 32'h1, "R6 clear bit1 only");
        bus_write(4'd3, 32'h1);
        expect_reg(4'd3, 32'h0, "R6 clear bit0");
        check(irq == 1'b0, "R8 low after clear", 32'(irq), 0);

        // R7 event wins over same-cycle clear
        send_fence(32'h6);
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 32'h3; bus_wr = 1'b1; fence_valid = 1'b1; fence_value = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0; fence_valid = 1'b0;
        expect_reg(4'd3, 32'h1, "R7 fence beats clear");
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 32'h3; bus_wr = 1'b1; progress_pulse = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; progress_pulse = 1'b0;
        expect_reg(4'd3, 32'h2, "R7 progress beats clear");

        // R9 R11 R12 sync write
        check(wake_pulse == 1'b0, "R12 wake idle", 32'(wake_pulse), 0);
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 32'hABCD_0123; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(wake_pulse == 1'b1, "R12 wake high", 32'(wake_pulse), 1);
        @(negedge clk);
        check(wake_pulse == 1'b0, "R12 wake one cycle", 32'(wake_pulse), 0);
        expect_reg(4'd5, 32'h1, "R9 busy set");
        expect_reg(4'd4, 32'hABCD_0123, "R11 reason");
        repeat (5) @(negedge clk);
        expect_reg(4'd5, 32'h1, "R10 busy holds");

        // R10 drain coinciding with sync write
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 32'h55; bus_wr = 1'b1; drained_pulse = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; drained_pulse = 1'b0;
        check(wake_pulse == 1'b1, "R12 wake while busy", 32'(wake_pulse), 1);
        expect_reg(4'd5, 32'h1, "R10 drain+sync keeps busy");
        expect_reg(4'd4, 32'h55, "R11 reason updated");

        // R10 drain alone clears
        @(negedge clk); drained_pulse = 1'b1;
        @(negedge clk); drained_pulse = 1'b0;
        expect_reg(4'd5, 32'h0, "R10 drain clears busy");
        @(negedge clk); drained_pulse = 1'b1;
        @(negedge clk); drained_pulse = 1'b0;
        expect_reg(4'd5, 32'h0, "R10 drain idle no effect");
        check(wake_pulse == 1'b0, "R12 no wake on drain", 32'(wake_pulse), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule